// File: doc/BRIEF.md
# Snoop Acknowledge Collector with Timeout

This block sits beside a shared coherence bus and runs on the bus clock. A snoop command is broadcast on that clock, and the order of these broadcasts alone sets the global order of operations. Several processor agents then answer. Each agent runs on its own clock and replies without any timing relation to the bus. An agent answers by inverting a one-bit toggle line. The collector passes each toggle through its own two-flop synchronizer exactly once. It treats a change of the synchronized level as one answer and keeps a record of which agents have replied.

Only one snoop may be outstanding at a time. When every agent that was enabled at issue time has answered, the collector emits a one-cycle completion pulse and clears its record. A programmable counter bounds the wait so that a silent agent cannot stall the bus. When the counter runs out, a timeout pulse is raised, the set of missing agents is reported, and the collector goes back to idle. A toggle change that arrives when no snoop is open is dropped and flagged.

Top module: `snoop_ack_collector`

## Requirements
- R1: A snoop request (snoopIssue high at a clock edge) is accepted only while busy is low. Once accepted, busy is high from the next cycle on. A request made while busy is high has no effect.
- R2: A change of an agent's toggle input that is present before a clock edge is counted at the third bus clock edge from that point. The first two edges load the two synchronizer flops, and the third edge registers the answer.
- R3: Completion is signalled when every enabled agent has answered. At the edge that registers the last needed answer, busy falls and snoopDone is high for exactly one cycle. The answer record starts empty for the next snoop, so an agent must toggle again to answer it.
- R4: The enable mask is sampled when the snoop is accepted. Bit i set means agent i is awaited. An agent whose bit is clear counts as already answered. With all bits clear, completion comes one cycle after acceptance.
- R5: With limit L on timeoutLimit at acceptance (L = 0 is treated as 1), if the snoop has not completed at the L-th edge after the accepting edge, timeoutFlag pulses for one cycle and busy falls. If completion and expiry fall on the same edge, completion wins.
- R6: At a timeout, missingMask takes the enabled agents that have not answered (bit i for agent i). It holds that value until the next snoop is accepted, which clears it to zero.
- R7: A toggle change counted while busy is low is not recorded as an answer. It raises strayAck for one cycle instead.
- R8: While a snoop is open, a second toggle from an agent that has already answered has no effect. A toggle from an agent that is not enabled also has no effect.
- R9: During reset, busy, snoopDone, timeoutFlag and strayAck are low, and missingMask is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Asynchronous reset, active low |
| snoopIssue | input | 1 | Snoop broadcast strobe |
| agentEnable | input | NUM_AGENTS | Agents to await, sampled at acceptance |
| timeoutLimit | input | TIMER_W | Wait limit in bus cycles, sampled at acceptance |
| ackToggle | input | NUM_AGENTS | Per-agent acknowledge toggles, asynchronous |
| busy | output | 1 | A snoop is outstanding |
| snoopDone | output | 1 | One-cycle completion pulse |
| timeoutFlag | output | 1 | One-cycle timeout pulse |
| missingMask | output | NUM_AGENTS | Agents that did not answer the last timed-out snoop |
| strayAck | output | 1 | One-cycle pulse for an answer seen while idle |

## Verification
The hardest cases to reach from the ports are those where an answer lands on the same edge as a state change. Examples are an answer that clears the synchronizer on the very edge that accepts a snoop, and a last answer that arrives on the expiry edge. The bench reaches these by toggling agents a chosen number of cycles before an issue or before the limit. It sweeps that offset across the three-cycle synchronizer delay. A behavioural model compares every output on every cycle.

// File: rtl/snoop_col_pkg.sv
package snoop_col_pkg;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_WAIT = 1'b1
  } colState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic startSnoop;    // capture enables, limit; clear record
    logic countTick;     // absorb answers, advance timer
    logic closeOk;       // all answered
    logic closeTimeout;  // limit reached
  } colStrobes_t;

endpackage

// File: rtl/snoop_ack_sync.sv
module snoop_ack_sync #(
  parameter int NUM_AGENTS  = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [NUM_AGENTS-1:0] ackToggle,
  output logic [NUM_AGENTS-1:0] ackEvent
);

  localparam int LAST = SYNC_STAGES - 1;

  for (genvar g = 0; g < NUM_AGENTS; g++) begin : gAgent
    logic [SYNC_STAGES-1:0] chainQ;
    logic                   prevQ;

    // single synchronizer per agent, fanned out only after prevQ
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        chainQ <= '0;
        prevQ  <= 1'b0;
      end else begin
        chainQ <= {chainQ[SYNC_STAGES-2:0], ackToggle[g]};
        prevQ  <= chainQ[LAST];
      end
    end

    assign ackEvent[g] = chainQ[LAST] ^ prevQ;
  end

endmodule

// File: rtl/snoop_col_datapath.sv
module snoop_col_datapath
  import snoop_col_pkg::*;
#(
  parameter int NUM_AGENTS = 4,
  parameter int TIMER_W    = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  colStrobes_t           strobes,
  input  logic [NUM_AGENTS-1:0] agentEnable,
  input  logic [TIMER_W-1:0]    timeoutLimit,
  input  logic [NUM_AGENTS-1:0] ackEvent,
  output logic                  allAnswered,
  output logic                  timerExpired,
  output logic [NUM_AGENTS-1:0] missingMask
);

  localparam logic [TIMER_W-1:0] ONE = TIMER_W'(1);

  logic [NUM_AGENTS-1:0] enQ;
  logic [NUM_AGENTS-1:0] respQ;
  logic [NUM_AGENTS-1:0] missQ;
  logic [NUM_AGENTS-1:0] gotNow;
  logic [TIMER_W-1:0]    limitQ;
  logic [TIMER_W-1:0]    cntQ;

  assign gotNow       = respQ | (ackEvent & enQ);
  assign allAnswered  = &(gotNow | ~enQ);
  assign timerExpired = (cntQ == (limitQ - ONE));
  assign missingMask  = missQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      enQ    <= '0;
      respQ  <= '0;
      missQ  <= '0;
      limitQ <= ONE;
      cntQ   <= '0;
    end else if (strobes.startSnoop) begin
      enQ    <= agentEnable;
      limitQ <= (timeoutLimit == '0) ? ONE : timeoutLimit;
      cntQ   <= '0;
      respQ  <= '0;
      missQ  <= '0;
    end else if (strobes.closeOk) begin
      respQ  <= '0;
    end else if (strobes.closeTimeout) begin
      respQ  <= '0;
      missQ  <= enQ & ~gotNow;
    end else if (strobes.countTick) begin
      respQ  <= gotNow;
      cntQ   <= cntQ + ONE;
    end
  end

endmodule

// File: rtl/snoop_col_control.sv
module snoop_col_control
  import snoop_col_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        snoopIssue,
  input  logic        allAnswered,
  input  logic        timerExpired,
  input  logic        anyAckEvent,
  output colStrobes_t strobes,
  output logic        busy,
  output logic        snoopDone,
  output logic        timeoutFlag,
  output logic        strayAck
);

  colState_t stateQ;
  colState_t stateD;
  logic      doneQ;
  logic      timeoutQ;
  logic      strayQ;

  always_comb begin
    strobes = '0;
    stateD  = stateQ;
    case (stateQ)
      ST_IDLE: begin
        if (snoopIssue) begin
          strobes.startSnoop = 1'b1;
          stateD             = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (allAnswered) begin
          strobes.closeOk = 1'b1;
          stateD          = ST_IDLE;
        end else if (timerExpired) begin
          strobes.closeTimeout = 1'b1;
          stateD               = ST_IDLE;
        end else begin
          strobes.countTick = 1'b1;
        end
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stateQ   <= ST_IDLE;
      doneQ    <= 1'b0;
      timeoutQ <= 1'b0;
      strayQ   <= 1'b0;
    end else begin
      stateQ   <= stateD;
      doneQ    <= strobes.closeOk;
      timeoutQ <= strobes.closeTimeout;
      strayQ   <= (stateQ == ST_IDLE) && anyAckEvent;
    end
  end

  assign busy        = (stateQ == ST_WAIT);
  assign snoopDone   = doneQ;
  assign timeoutFlag = timeoutQ;
  assign strayAck    = strayQ;

endmodule

// File: rtl/snoop_ack_collector.sv
module snoop_ack_collector
  import snoop_col_pkg::*;
#(
  parameter int NUM_AGENTS  = 4,
  parameter int TIMER_W     = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  snoopIssue,
  input  logic [NUM_AGENTS-1:0] agentEnable,
  input  logic [TIMER_W-1:0]    timeoutLimit,
  input  logic [NUM_AGENTS-1:0] ackToggle,
  output logic                  busy,
  output logic                  snoopDone,
  output logic                  timeoutFlag,
  output logic [NUM_AGENTS-1:0] missingMask,
  output logic                  strayAck
);

  logic [NUM_AGENTS-1:0] ackEvent;
  logic                  allAnswered;
  logic                  timerExpired;
  colStrobes_t           strobes;

  snoop_ack_sync #(
    .NUM_AGENTS (NUM_AGENTS),
    .SYNC_STAGES(SYNC_STAGES)
  ) uSync (
    .clk      (clk),
    .rstN     (rstN),
    .ackToggle(ackToggle),
    .ackEvent (ackEvent)
  );

  snoop_col_datapath #(
    .NUM_AGENTS(NUM_AGENTS),
    .TIMER_W   (TIMER_W)
  ) uDp (
    .clk         (clk),
    .rstN        (rstN),
    .strobes     (strobes),
    .agentEnable (agentEnable),
    .timeoutLimit(timeoutLimit),
    .ackEvent    (ackEvent),
    .allAnswered (allAnswered),
    .timerExpired(timerExpired),
    .missingMask (missingMask)
  );

  snoop_col_control uCtl (
    .clk         (clk),
    .rstN        (rstN),
    .snoopIssue  (snoopIssue),
    .allAnswered (allAnswered),
    .timerExpired(timerExpired),
    .anyAckEvent (|ackEvent),
    .strobes     (strobes),
    .busy        (busy),
    .snoopDone   (snoopDone),
    .timeoutFlag (timeoutFlag),
    .strayAck    (strayAck)
  );

endmodule

// File: rtl/snoop_col_checker.sv
module snoop_col_checker #(
  parameter int NUM_AGENTS = 4,
  parameter int TIMER_W    = 16
) (
  input logic                  clk,
  input logic                  rstN,
  input logic                  snoopIssue,
  input logic                  busy,
  input logic                  snoopDone,
  input logic                  timeoutFlag,
  input logic [NUM_AGENTS-1:0] missingMask,
  input logic                  strayAck
);

  AST_ISSUE_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && snoopIssue) |=> busy); // R1

  AST_DONE_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    snoopDone |-> (!busy && $past(busy))); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    snoopDone |=> !snoopDone); // R3

  AST_CLOSE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({snoopDone, timeoutFlag})); // R5

  AST_TIMEOUT_ENDS_WAIT: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> (!busy && $past(busy))); // R5

  AST_MISSING_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag |-> (missingMask != '0)); // R6

  AST_MISSING_CLEAR_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> (missingMask == '0)); // R6

  AST_STRAY_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    strayAck |-> !$past(busy)); // R7

endmodule

bind snoop_ack_collector snoop_col_checker #(
  .NUM_AGENTS(NUM_AGENTS),
  .TIMER_W   (TIMER_W)
) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .snoopIssue (snoopIssue),
  .busy       (busy),
  .snoopDone  (snoopDone),
  .timeoutFlag(timeoutFlag),
  .missingMask(missingMask),
  .strayAck   (strayAck)
);

// File: tb/sim_snoop_ack_collector.sv
module sim_snoop_ack_collector;

  localparam int N  = 4;
  localparam int TW = 16;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          snoopIssue = 1'b0;
  logic [N-1:0]  agentEnable = '0;
  logic [TW-1:0] timeoutLimit = '0;
  logic [N-1:0]  ackToggle = '0;
  logic          busy, snoopDone, timeoutFlag, strayAck;
  logic [N-1:0]  missingMask;

  int checks = 0;
  int fails  = 0;
  string curReq = "R9";

  always #2 clk = ~clk; // 250 MHz

  snoop_ack_collector #(.NUM_AGENTS(N), .TIMER_W(TW)) u0 (
    .clk(clk), .rstN(rstN), .snoopIssue(snoopIssue), .agentEnable(agentEnable),
    .timeoutLimit(timeoutLimit), .ackToggle(ackToggle), .busy(busy),
    .snoopDone(snoopDone), .timeoutFlag(timeoutFlag), .missingMask(missingMask),
    .strayAck(strayAck)
  );

  // behavioural reference model
  bit       mBusy, mDone, mTo, mStray;
  bit [3:0] mMiss, mResp, mEn, s1, s2, pv, ev, got;
  int       mCnt, mLimit;

  always @(posedge clk) begin
    if (!rstN) begin
      mBusy = 0; mDone = 0; mTo = 0; mStray = 0; mMiss = 0; mResp = 0;
      mEn = 0; mCnt = 0; mLimit = 1; s1 = 0; s2 = 0; pv = 0;
    end else begin
      ev = s2 ^ pv;
      mDone = 0; mTo = 0; mStray = 0;
      if (!mBusy) begin
        mStray = (ev != 0);
        if (snoopIssue) begin
          mBusy = 1; mEn = agentEnable; mCnt = 0; mResp = 0; mMiss = 0;
          mLimit = (timeoutLimit == 0) ? 1 : int'(timeoutLimit);
        end
      end else begin
        got = mResp | (ev & mEn);
        if ((got | ~mEn) == 4'hF) begin
          mDone = 1; mBusy = 0; mResp = 0;
        end else if (mCnt == mLimit - 1) begin
          mTo = 1; mBusy = 0; mResp = 0; mMiss = mEn & ~got;
        end else begin
          mResp = got; mCnt++;
        end
      end
      pv = s2; s2 = s1; s1 = ackToggle;
    end
  end

  task automatic cmp(string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s (%s) t=%0t actual=%0h expected=%0h", curReq, what, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rstN) begin
      cmp("busy R1", busy, mBusy);
      cmp("done R3", snoopDone, mDone);
      cmp("timeout R5", timeoutFlag, mTo);
      cmp("missing R6", missingMask, mMiss);
      cmp("stray R7", strayAck, mStray);
    end
  end

  task automatic tick(int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic issue(logic [3:0] en, int lim);
    agentEnable = en; timeoutLimit = TW'(lim); snoopIssue = 1'b1;
    tick(1);
    snoopIssue = 1'b0;
  endtask

  task automatic tog(int a);
    ackToggle[a] = ~ackToggle[a];
  endtask

  initial begin
    tick(2);
    curReq = "R9";
    cmp("reset busy R9", busy, 0);
    cmp("reset done R9", snoopDone, 0);
    cmp("reset timeout R9", timeoutFlag, 0);
    cmp("reset stray R9", strayAck, 0);
    cmp("reset missing R9", missingMask, 0);
    rstN = 1'b1;
    tick(2);

    // R2 / R3: all agents, staggered answers
    curReq = "R2";
    issue(4'hF, 40);
    tog(0); tick(1); tog(2); tick(3); tog(1); tick(2);
    curReq = "R1";
    snoopIssue = 1'b1; tick(1); snoopIssue = 1'b0; // ignored while busy
    curReq = "R3";
    tog(3); tick(8);
    // second snoop needs fresh answers
    issue(4'hF, 12);
    tog(3); tog(1); tick(2); tog(0); tog(2); tick(8);

    // R4: partial and empty enable
    curReq = "R4";
    issue(4'b0101, 30);
    tog(0); tick(2); tog(2); tick(8);
    issue(4'b0000, 30); tick(4);

    // R5 / R6: timeout with one missing agent set
    curReq = "R5";
    issue(4'hF, 6);
    tog(1); tick(10);
    curReq = "R6";
    tick(3);
    issue(4'b0011, 0); tick(4); // limit zero behaves as one
    curReq = "R5";
    // last answer near expiry edge: sweep offsets
    for (int off = 0; off < 5; off++) begin
      issue(4'b0001, 5);
      tick(off);
      tog(0);
      tick(12);
    end

    // R7: stray while idle, also near an issue edge
    curReq = "R7";
    tog(3); tick(6);
    for (int off = 0; off < 4; off++) begin
      tog(2); tick(off);
      issue(4'b0100, 20);
      tick(25);
    end

    // R8: duplicate and disabled-agent toggles
    curReq = "R8";
    issue(4'b0011, 30);
    tog(0); tick(4); tog(0); tick(4); tog(3); tick(4); tog(1); tick(8);
    issue(4'b0110, 8);
    tog(1); tick(4); tog(1); tog(0); tick(12);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog %s actual=hung expected=finished", curReq);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule